// File: doc/BRIEF.md
# Byte-to-Word Write Packer

This block sits between a byte-oriented write client and a word program engine for a NOR-style array that can only clear bits. A client hands it a byte start address and a byte count. It then streams the bytes in. The packer gathers them into aligned 32-bit words and offers each word, with its aligned byte address, to the program engine. It waits for a done or error response before it starts the next word. Lanes that the request does not cover are padded with 0xFF, so the program step leaves those lanes of the array unchanged.

When the request ends, the block raises a one-cycle completion pulse. The pulse carries a status code and the number of request bytes committed to the array. The packer rejects a zero-length request at once and also rejects a request that runs past the array end. On the first program error it stops and reports how far it got.

Top module: `wpack_top`

## Requirements
- R1: A request with a byte count of zero completes with status OK (code 0) and a committed count of 0. The completion pulse comes one cycle after acceptance. No word is issued and no byte is consumed.
- R2: A request whose start address plus byte count is greater than ARRAY_BYTES completes with status RANGE (code 1) and a count of 0. No word is issued and no byte is consumed. A request ending exactly at ARRAY_BYTES is accepted.
- R3: When the start address is not word-aligned, the first word goes to the aligned address just below the start. Its lanes below the start offset hold 0xFF. The following lanes take request bytes in order. Any lanes still left over hold 0xFF.
- R4: After the first word, each complete group of 4 request bytes leaves as one full word, and word addresses rise by 4 each time.
- R5: A final group of 1 to 3 bytes leaves as one word. Its low lanes carry the bytes and its upper lanes carry 0xFF.
- R6: Byte lane n sits at word data bits 8n+7:8n, so the request byte at the lowest address lands in bits 7:0 when it starts a word.
- R7: When the engine reports an error for a word, the packer issues no further words and consumes no further bytes. It completes with status IO (code 2).
- R8: The committed count grows only by the request bytes carried in each word the engine reports done. Padding lanes and the failed word are never counted, so a clean request reports its full byte count.
- R9: An offered word keeps its address and data stable until the engine accepts it. The next word is offered only after the engine responds, and no byte is consumed while a word is offered or outstanding.
- R10: The completion pulse lasts exactly one cycle. A new request is accepted only while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request taken this cycle if valid |
| reqAddr | input | ADDR_W | Byte start address |
| reqLen | input | ADDR_W+1 | Byte count |
| byteValid | input | 1 | Byte stream data present |
| byteReady | output | 1 | Byte taken this cycle if valid |
| byteData | input | 8 | Stream byte |
| wordValid | output | 1 | Word offered to the program engine |
| wordReady | input | 1 | Engine accepts the offered word |
| wordAddr | output | ADDR_W | Aligned byte address of the word |
| wordData | output | 32 | Packed word, lane 0 in bits 7:0 |
| progDone | input | 1 | Engine reports the outstanding word programmed |
| progErr | input | 1 | Engine reports the outstanding word failed |
| doneValid | output | 1 | One-cycle completion pulse |
| doneStatus | output | 2 | 0 OK, 1 RANGE, 2 IO |
| doneCount | output | ADDR_W+1 | Request bytes committed |

## Verification
For a zero-length or out-of-range request, the completion pulse is due one cycle after the accepting edge, since only the state register lies in between. The bench counts falling edges from acceptance and expects the pulse at the first one. For any other request, the pulse follows the engine's final done or error response by one cycle. The bench therefore waits for the pulse, samples the status and count on a falling edge, and then checks that the pulse is gone on the next falling edge. The bench records words at the accepting edge of the word handshake and compares them afterwards with words it builds from the request bytes. Because the bench engine answers three cycles after each acceptance, the step-by-step stalls are covered as well.

// File: rtl/wpack_pkg.sv
`timescale 1ns/1ps
package wpack_pkg;

  typedef enum logic [1:0] {
    STAT_OK    = 2'd0,
    STAT_RANGE = 2'd1,
    STAT_IO    = 2'd2
  } wpStatus_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FILL,
    S_SEND,
    S_WAIT,
    S_DONE
  } wpState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture request, clear counters, preset word
    logic take;    // place stream byte into current lane
    logic commit;  // word programmed: add chunk, step address
  } dpCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic zeroLen;
    logic rangeBad;
    logic lastLane;
    logic lastByte;
    logic noneLeft;
  } dpFlag_t;

endpackage

// File: rtl/wpack_dp.sv
`timescale 1ns/1ps
module wpack_dp
  import wpack_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ARRAY_BYTES = 49152,
  parameter int WORD_BYTES  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [ADDR_W:0]         reqLen,
  input  logic [7:0]              byteData,
  output dpFlag_t                 flag,
  output logic [ADDR_W-1:0]       wordAddr,
  output logic [WORD_BYTES*8-1:0] wordData,
  output logic [ADDR_W:0]         doneCount
);

  localparam int LEN_W  = ADDR_W + 1;
  localparam int LANE_W = $clog2(WORD_BYTES);
  localparam int CHK_W  = LANE_W + 1;

  logic [ADDR_W-1:0] baseAddr;
  logic [LANE_W-1:0] laneIdx;
  logic [LEN_W-1:0]  remain;
  logic [LEN_W-1:0]  committed;
  logic [CHK_W-1:0]  chunk;
  logic [LEN_W:0]    endAddr;

  assign endAddr = {2'b00, reqAddr} + {1'b0, reqLen};

  always_comb begin
    flag.zeroLen  = (reqLen == '0);
    flag.rangeBad = (endAddr > (LEN_W+1)'(ARRAY_BYTES));
    flag.lastLane = (laneIdx == LANE_W'(WORD_BYTES-1));
    flag.lastByte = (remain == LEN_W'(1));
    flag.noneLeft = (remain == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr  <= '0;
      laneIdx   <= '0;
      remain    <= '0;
      committed <= '0;
      chunk     <= '0;
    end else if (ctl.load) begin
      baseAddr  <= {reqAddr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
      laneIdx   <= reqAddr[LANE_W-1:0];
      remain    <= reqLen;
      committed <= '0;
      chunk     <= '0;
    end else if (ctl.take) begin
      laneIdx <= laneIdx + LANE_W'(1);
      remain  <= remain - LEN_W'(1);
      chunk   <= chunk + CHK_W'(1);
    end else if (ctl.commit) begin
      committed <= committed + LEN_W'(chunk);
      chunk     <= '0;
      laneIdx   <= '0;
      baseAddr  <= baseAddr + ADDR_W'(WORD_BYTES);
    end
  end

  // one register per byte lane, preset to erased value
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    logic [7:0] laneReg;
    always_ff @(posedge clk) begin
      if (!rstN || ctl.load || ctl.commit) begin
        laneReg <= 8'hFF;
      end else if (ctl.take && (laneIdx == LANE_W'(g))) begin
        laneReg <= byteData;
      end
    end
    assign wordData[g*8 +: 8] = laneReg;
  end

  assign wordAddr  = baseAddr;
  assign doneCount = committed;

endmodule

// File: rtl/wpack_ctrl.sv
`timescale 1ns/1ps
module wpack_ctrl
  import wpack_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  input  logic      byteValid,
  output logic      byteReady,
  output logic      wordValid,
  input  logic      wordReady,
  input  logic      progDone,
  input  logic      progErr,
  input  dpFlag_t   flag,
  output dpCtl_t    ctl,
  output logic      doneValid,
  output logic [1:0] doneStatus
);

  wpState_e  state, stateNxt;
  wpStatus_e status, statusNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      status <= STAT_OK;
    end else begin
      state  <= stateNxt;
      status <= statusNxt;
    end
  end

  always_comb begin
    stateNxt  = state;
    statusNxt = status;
    ctl       = '0;
    reqReady  = 1'b0;
    byteReady = 1'b0;
    wordValid = 1'b0;
    doneValid = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.load = 1'b1;
          if (flag.zeroLen) begin
            statusNxt = STAT_OK;
            stateNxt  = S_DONE;
          end else if (flag.rangeBad) begin
            statusNxt = STAT_RANGE;
            stateNxt  = S_DONE;
          end else begin
            stateNxt = S_FILL;
          end
        end
      end
      S_FILL: begin
        byteReady = 1'b1;
        if (byteValid) begin
          ctl.take = 1'b1;
          if (flag.lastLane || flag.lastByte) stateNxt = S_SEND;
        end
      end
      S_SEND: begin
        wordValid = 1'b1;
        if (wordReady) stateNxt = S_WAIT;
      end
      S_WAIT: begin
        if (progErr) begin
          statusNxt = STAT_IO;
          stateNxt  = S_DONE;
        end else if (progDone) begin
          ctl.commit = 1'b1;
          if (flag.noneLeft) begin
            statusNxt = STAT_OK;
            stateNxt  = S_DONE;
          end else begin
            stateNxt = S_FILL;
          end
        end
      end
      S_DONE: begin
        doneValid = 1'b1;
        stateNxt  = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign doneStatus = status;

endmodule

// File: rtl/wpack_top.sv
`timescale 1ns/1ps
module wpack_top
  import wpack_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ARRAY_BYTES = 49152
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W:0]   reqLen,
  input  logic              byteValid,
  output logic              byteReady,
  input  logic [7:0]        byteData,
  output logic              wordValid,
  input  logic              wordReady,
  output logic [ADDR_W-1:0] wordAddr,
  output logic [31:0]       wordData,
  input  logic              progDone,
  input  logic              progErr,
  output logic              doneValid,
  output logic [1:0]        doneStatus,
  output logic [ADDR_W:0]   doneCount
);

  dpCtl_t  ctl;
  dpFlag_t flag;

  wpack_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .byteValid  (byteValid),
    .byteReady  (byteReady),
    .wordValid  (wordValid),
    .wordReady  (wordReady),
    .progDone   (progDone),
    .progErr    (progErr),
    .flag       (flag),
    .ctl        (ctl),
    .doneValid  (doneValid),
    .doneStatus (doneStatus)
  );

  wpack_dp #(
    .ADDR_W      (ADDR_W),
    .ARRAY_BYTES (ARRAY_BYTES),
    .WORD_BYTES  (4)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .reqLen    (reqLen),
    .byteData  (byteData),
    .flag      (flag),
    .wordAddr  (wordAddr),
    .wordData  (wordData),
    .doneCount (doneCount)
  );

endmodule

// File: rtl/wpack_chk.sv
`timescale 1ns/1ps
module wpack_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              byteReady,
  input logic              wordValid,
  input logic              wordReady,
  input logic [ADDR_W-1:0] wordAddr,
  input logic [31:0]       wordData,
  input logic              doneValid,
  input logic [1:0]        doneStatus,
  input logic [ADDR_W:0]   doneCount
);

  // R4: every offered word sits on a word boundary
  p_word_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (wordAddr[1:0] == 2'b00));

  // R9: offered word held until accepted
  p_word_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordReady) |=> (wordValid && $stable(wordAddr) && $stable(wordData)));

  // R9: no byte consumed while a word is on offer
  p_no_byte_during_word_r9: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> !wordValid);

  // R10: completion pulse is one cycle wide
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R10: request intake only while idle
  p_idle_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!byteReady && !wordValid && !doneValid));

  // R2: a rejected request commits nothing
  p_range_no_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStatus == 2'd1) |-> (doneCount == '0));

endmodule

bind wpack_top wpack_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqReady   (reqReady),
  .byteReady  (byteReady),
  .wordValid  (wordValid),
  .wordReady  (wordReady),
  .wordAddr   (wordAddr),
  .wordData   (wordData),
  .doneValid  (doneValid),
  .doneStatus (doneStatus),
  .doneCount  (doneCount)
);

// File: tb/wpack_top_bench.sv
`timescale 1ns/1ps
module wpack_top_bench;

  localparam int AW  = 16;
  localparam int ARR = 49152;
  localparam int NOERR = 99;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic [AW:0]   reqLen = '0;
  logic          byteValid;
  logic          byteReady;
  logic [7:0]    byteData;
  logic          wordValid;
  logic          wordReady;
  logic [AW-1:0] wordAddr;
  logic [31:0]   wordData;
  logic          progDone = 1'b0;
  logic          progErr = 1'b0;
  logic          doneValid;
  logic [1:0]    doneStatus;
  logic [AW:0]   doneCount;

  wpack_top #(.ADDR_W(AW), .ARRAY_BYTES(ARR)) u_wpack_top (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqLen(reqLen),
    .byteValid(byteValid), .byteReady(byteReady), .byteData(byteData),
    .wordValid(wordValid), .wordReady(wordReady), .wordAddr(wordAddr), .wordData(wordData),
    .progDone(progDone), .progErr(progErr),
    .doneValid(doneValid), .doneStatus(doneStatus), .doneCount(doneCount)
  );

  int nChecks = 0;
  int nFails  = 0;

  // byte source
  logic [7:0] mem [0:63];
  int nBytes = 0;
  int bIdx = 0;
  logic clr = 1'b0;
  assign byteValid = (bIdx < nBytes);
  assign byteData  = mem[bIdx[5:0]];
  always @(posedge clk) begin
    if (clr) bIdx <= 0;
    else if (byteValid && byteReady) bIdx <= bIdx + 1;
  end

  // program engine model: stalls acceptance on alternate cycles, replies after 3
  logic rdyTog = 1'b0;
  always @(posedge clk) rdyTog <= ~rdyTog;
  assign wordReady = rdyTog;

  logic [AW-1:0] capA [0:31];
  logic [31:0]   capD [0:31];
  int nWords = 0;
  int errAt = NOERR;
  int lat = 0;
  logic errHit = 1'b0;
  always @(posedge clk) begin
    progDone <= 1'b0;
    progErr  <= 1'b0;
    if (clr) begin
      nWords <= 0;
      lat    <= 0;
    end else begin
      if (lat > 0) begin
        lat <= lat - 1;
        if (lat == 1) begin
          if (errHit) progErr <= 1'b1;
          else        progDone <= 1'b1;
        end
      end
      if (wordValid && wordReady) begin
        capA[nWords[4:0]] <= wordAddr;
        capD[nWords[4:0]] <= wordData;
        errHit <= (nWords == errAt);
        nWords <= nWords + 1;
        lat    <= 3;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  int gotStat, gotCnt, doneCyc;

  // issue one request and wait for the completion pulse
  task automatic runReq(input int addr, input int len, input int errWord, input int seed);
    @(negedge clk);
    for (int i = 0; i < 64; i++) mem[i] = 8'((seed + i * 37) & 8'hFF);
    errAt = errWord;
    nBytes = (len > 64) ? 64 : len;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    reqAddr = AW'(addr);
    reqLen  = (AW+1)'(len);
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    doneCyc = 0;
    gotStat = -1;
    gotCnt = -1;
    for (int k = 1; k < 2000; k++) begin
      if (doneValid) begin
        doneCyc = k;
        gotStat = int'(doneStatus);
        gotCnt  = int'(doneCount);
        break;
      end
      @(negedge clk);
    end
    if (doneCyc == 0) chk("R10", "completion seen", 0, 1);
    @(negedge clk);
    chk("R10", "pulse gone next cycle", {31'b0, doneValid}, 0);
    chk("R10", "idle after completion", {31'b0, reqReady}, 1);
  endtask

  // compare captured words with words built from the request
  task automatic checkWords(input string req, input int addr, input int len, input int errWord);
    int off, nExp, nIss, expCnt, expUsed;
    logic [31:0] d;
    off = addr % 4;
    nExp = (off + len + 3) / 4;
    nIss = (errWord < nExp) ? errWord + 1 : nExp;
    expCnt = 0;
    expUsed = 0;
    for (int p = 0; p < len; p++) begin
      if ((off + p) / 4 < ((errWord < nExp) ? errWord : nExp)) expCnt++;
      if ((off + p) / 4 < nIss) expUsed++;
    end
    chk(req, "words issued", nWords, nIss);
    chk(req, "bytes consumed", bIdx, expUsed);
    chk("R8", "committed count", gotCnt, expCnt);
    chk(req, "status", gotStat, (errWord < nExp) ? 2 : 0);
    for (int k = 0; k < nIss && k < nWords; k++) begin
      d = 32'hFFFF_FFFF;
      for (int p = 0; p < len; p++)
        if ((off + p) / 4 == k) d[((off + p) % 4) * 8 +: 8] = mem[p];
      chk(req, $sformatf("word %0d addr", k), 32'(capA[k]), 32'(addr - off + 4 * k));
      chk("R6", $sformatf("word %0d data", k), capD[k], d);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10", "reset reqReady", {31'b0, reqReady}, 1);
    chk("R9", "reset wordValid", {31'b0, wordValid}, 0);
    chk("R9", "reset byteReady", {31'b0, byteReady}, 0);
    chk("R10", "reset doneValid", {31'b0, doneValid}, 0);
  endtask

  task automatic t_zero();
    runReq(16'h0123, 0, NOERR, 5);
    chk("R1", "zero status", gotStat, 0);
    chk("R1", "zero count", gotCnt, 0);
    chk("R1", "zero latency", doneCyc, 1);
    chk("R1", "zero words", nWords, 0);
    chk("R1", "zero bytes", bIdx, 0);
  endtask

  task automatic t_range();
    runReq(ARR - 2, 3, NOERR, 9);
    chk("R2", "over status", gotStat, 1);
    chk("R2", "over count", gotCnt, 0);
    chk("R2", "over latency", doneCyc, 1);
    chk("R2", "over words", nWords, 0);
    chk("R2", "over bytes", bIdx, 0);
    runReq(0, 65536, NOERR, 9);
    chk("R2", "huge status", gotStat, 1);
    chk("R2", "huge bytes", bIdx, 0);
    runReq(ARR - 4, 4, NOERR, 11);
    checkWords("R2", ARR - 4, 4, NOERR);
  endtask

  task automatic t_head();
    runReq(16'h0101, 2, NOERR, 20);
    checkWords("R3", 16'h0101, 2, NOERR);
    runReq(16'h0143, 1, NOERR, 21);
    checkWords("R3", 16'h0143, 1, NOERR);
  endtask

  task automatic t_full();
    runReq(16'h0200, 12, NOERR, 30);
    checkWords("R4", 16'h0200, 12, NOERR);
    runReq(16'h0303, 9, NOERR, 31);
    checkWords("R4", 16'h0303, 9, NOERR);
  endtask

  task automatic t_tail();
    runReq(16'h0400, 6, NOERR, 40);
    checkWords("R5", 16'h0400, 6, NOERR);
    runReq(16'h0502, 11, NOERR, 41);
    checkWords("R5", 16'h0502, 11, NOERR);
    runReq(16'h0600, 3, NOERR, 42);
    checkWords("R5", 16'h0600, 3, NOERR);
  endtask

  task automatic t_error();
    runReq(16'h0701, 14, 2, 50);
    checkWords("R7", 16'h0701, 14, 2);
    runReq(16'h0800, 8, 0, 51);
    checkWords("R7", 16'h0800, 8, 0);
    runReq(16'h0902, 5, NOERR, 52);
    checkWords("R7", 16'h0902, 5, NOERR);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_zero();
    t_range();
    t_head();
    t_full();
    t_tail();
    t_error();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule